// File: doc/BRIEF.md
# Up/Down Timer with Compare Flags

This block is a small timer/counter for a register-mapped peripheral. It holds a count register that moves on timer ticks, which are qualified by a three-bit clock-select field. It supports three counting sequences:

- a free-running upward count;
- a count that returns to zero after matching compare register A;
- a triangle that rises to the maximum value and then falls back to zero.

Two compare registers are checked against the count on every tick. Together with an overflow event, they set three sticky flags. Each flag drives an interrupt request through its own enable bit.

Software controls the block through a simple single-cycle register bus. It can write and read the control fields, the count, both compare values, the enables and the flags. Flags are cleared in either of two ways: pulse the matching acknowledge input, or write a one to the flag's bit. The count width is a parameter, W, which defaults to 8; MAX below means 2^W-1. The reset input is asynchronous, and the block releases it internally on the clock.

Top module: `updown_timer`

## Requirements
- R1: After reset every readable register reads zero, all flags and interrupt requests are low, and the count is zero.
- R2: Register addresses and fields:
  - Address 0: bits 1:0 hold mode[1:0].
  - Address 1: bits 2:0 hold clock-select, and bit 3 holds mode[2].
  - Address 2: the count.
  - Address 3: compare A.
  - Address 4: compare B.
  - Address 5: the enables.
  - Address 6: the flags.
  - Flag and enable bits are: bit 0 overflow, bit 1 compare A, bit 2 compare B.
  - Bits that are not defined, and address 7, read zero.
- R3: The count advances only in a cycle where tick is high and clock-select is nonzero. Software can read and write the count whatever the clock-select value.
- R4: A bus write to the count takes effect on the next edge and overrides any step or clear from a tick in the same cycle. That tick also sets no flag.
- R5: In mode 0, the count rises by one per tick and wraps from MAX to 0, and the overflow flag sets on that wrap tick. Any mode code other than 1 and 2 behaves as mode 0.
- R6: In mode 2, a tick that finds the count equal to compare A clears it to zero instead of incrementing.
- R7: Entering mode 1, the count starts in the upward direction. It turns downward at MAX and upward again at 0, which gives a period of 2*MAX ticks. The overflow flag sets on the tick that brings the count down to 0.
- R8: A compare flag sets on the tick that finds the count equal to its compare register. That is one tick after the count reached the value.
- R9: A flag clears when its acknowledge input is high or when a one is written to its bit. Writing a zero leaves it unchanged. A set in the same cycle wins over a clear.
- R10: Each interrupt request is high exactly when its flag and its enable bit are both set.
- R11: cnt_top is high while the count equals MAX. cnt_bottom is high while the count equals 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Timer tick enable |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | W | Write data |
| bus_rdata | output | W | Read data (combinational from address) |
| ack_ovf | input | 1 | Acknowledge for the overflow flag |
| ack_cmp_a | input | 1 | Acknowledge for the compare A flag |
| ack_cmp_b | input | 1 | Acknowledge for the compare B flag |
| flag_ovf | output | 1 | Overflow flag |
| flag_cmp_a | output | 1 | Compare A flag |
| flag_cmp_b | output | 1 | Compare B flag |
| irq_ovf | output | 1 | Overflow interrupt request |
| irq_cmp_a | output | 1 | Compare A interrupt request |
| irq_cmp_b | output | 1 | Compare B interrupt request |
| cnt_top | output | 1 | Count is at MAX |
| cnt_bottom | output | 1 | Count is at zero |

## Verification
The bench sweeps a full triangle period so that both turnarounds and the bottom-overflow tick are seen. A design that repeats a value at an endpoint or sets overflow at the top would drift from the computed sequence.

It checks the compare flag on the exact tick after the match. A flag that sets in the match cycle itself would be reported one tick early.

A count write is issued together with a tick, and with the count equal to compare A. A design that let the tick win would show one more than the written value, or a spurious flag.

Acknowledge and tick are raised together on a matching count, which exposes a clear that beats the set. Mode code 6 is run to catch a decoder that ignores bit 2 of the mode.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int AW = 3;
  localparam int NF = 3;

  localparam logic [AW-1:0] ADDR_CTRL0 = 3'd0;
  localparam logic [AW-1:0] ADDR_CTRL1 = 3'd1;
  localparam logic [AW-1:0] ADDR_COUNT = 3'd2;
  localparam logic [AW-1:0] ADDR_CMPA  = 3'd3;
  localparam logic [AW-1:0] ADDR_CMPB  = 3'd4;
  localparam logic [AW-1:0] ADDR_IEN   = 3'd5;
  localparam logic [AW-1:0] ADDR_FLAGS = 3'd6;

  localparam int FLG_OVF = 0;
  localparam int FLG_A   = 1;
  localparam int FLG_B   = 2;

  typedef logic [2:0] tmr_mode_t;
  localparam tmr_mode_t MODE_NORMAL = 3'd0;
  localparam tmr_mode_t MODE_UPDOWN = 3'd1;
  localparam tmr_mode_t MODE_CLRCMP = 3'd2;
endpackage

// File: rtl/tmr_regs.sv
module tmr_regs
  import tmr_pkg::*;
#(
  parameter int W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_wr,
  input  logic [AW-1:0]   bus_addr,
  input  logic [W-1:0]    bus_wdata,
  output tmr_mode_t       mode,
  output logic [2:0]      clksel,
  output logic [W-1:0]    cmp_a,
  output logic [W-1:0]    cmp_b,
  output logic [NF-1:0]   ien
);
  logic      we_ctrl0, we_ctrl1, we_cmpa, we_cmpb, we_ien;
  tmr_mode_t mode_d;
  logic [2:0] clksel_d;

  always_comb begin
    we_ctrl0 = bus_wr && (bus_addr == ADDR_CTRL0);
    we_ctrl1 = bus_wr && (bus_addr == ADDR_CTRL1);
    we_cmpa  = bus_wr && (bus_addr == ADDR_CMPA);
    we_cmpb  = bus_wr && (bus_addr == ADDR_CMPB);
    we_ien   = bus_wr && (bus_addr == ADDR_IEN);
    mode_d   = mode;
    clksel_d = clksel;
    if (we_ctrl0) mode_d[1:0] = bus_wdata[1:0];
    if (we_ctrl1) begin
      mode_d[2] = bus_wdata[3];
      clksel_d  = bus_wdata[2:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode   <= MODE_NORMAL;
      clksel <= '0;
    end else if (we_ctrl0 || we_ctrl1) begin
      mode   <= mode_d;
      clksel <= clksel_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cmp_a <= '0;
    else if (we_cmpa) cmp_a <= bus_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cmp_b <= '0;
    else if (we_cmpb) cmp_b <= bus_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ien <= '0;
    else if (we_ien) ien <= bus_wdata[NF-1:0];
  end
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter
  import tmr_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         adv,
  input  tmr_mode_t    mode,
  input  logic [W-1:0] cmp_a,
  input  logic         cnt_wr,
  input  logic [W-1:0] cnt_wdata,
  output logic [W-1:0] cnt,
  output logic         at_top,
  output logic         at_bottom,
  output logic         ovf_evt
);
  localparam logic [W-1:0] MAXV = '1;
  localparam logic [W-1:0] ONE  = {{(W-1){1'b0}}, 1'b1};

  logic         dir_q, dir_d, step_down;
  logic [W-1:0] cnt_d;
  logic         cnt_en;

  assign at_top    = (cnt == MAXV);
  assign at_bottom = (cnt == '0);

  always_comb begin
    step_down = dir_q;
    dir_d     = dir_q;
    cnt_d     = cnt;
    ovf_evt   = 1'b0;
    cnt_en    = cnt_wr || adv;
    if (mode != MODE_UPDOWN) dir_d = 1'b0;
    if (cnt_wr) begin
      cnt_d = cnt_wdata;
    end else if (adv) begin
      if (mode == MODE_UPDOWN) begin
        if (at_top)         step_down = 1'b1;
        else if (at_bottom) step_down = 1'b0;
        dir_d   = step_down;
        cnt_d   = step_down ? (cnt - ONE) : (cnt + ONE);
        ovf_evt = step_down && (cnt == ONE);
      end else if ((mode == MODE_CLRCMP) && (cnt == cmp_a)) begin
        cnt_d   = '0;
        ovf_evt = at_top;
      end else begin
        cnt_d   = cnt + ONE;
        ovf_evt = at_top;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (cnt_en) cnt <= cnt_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dir_q <= 1'b0;
    else        dir_q <= dir_d;
  end
endmodule

// File: rtl/tmr_flags.sv
module tmr_flags #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_vec,
  input  logic [N-1:0] clr_vec,
  input  logic [N-1:0] ien,
  output logic [N-1:0] flags,
  output logic [N-1:0] irq
);
  logic [N-1:0] flags_d;

  for (genvar i = 0; i < N; i++) begin : g_flag
    always_comb begin
      if (set_vec[i])      flags_d[i] = 1'b1;
      else if (clr_vec[i]) flags_d[i] = 1'b0;
      else                 flags_d[i] = flags[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flags[i] <= 1'b0;
      else        flags[i] <= flags_d[i];
    end
  end

  assign irq = flags & ien;
endmodule

// File: rtl/updown_timer.sv
module updown_timer
  import tmr_pkg::*;
#(
  parameter int W = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          bus_wr,
  input  logic [2:0]    bus_addr,
  input  logic [W-1:0]  bus_wdata,
  output logic [W-1:0]  bus_rdata,
  input  logic          ack_ovf,
  input  logic          ack_cmp_a,
  input  logic          ack_cmp_b,
  output logic          flag_ovf,
  output logic          flag_cmp_a,
  output logic          flag_cmp_b,
  output logic          irq_ovf,
  output logic          irq_cmp_a,
  output logic          irq_cmp_b,
  output logic          cnt_top,
  output logic          cnt_bottom
);
  logic          rst_meta, rst_sync;
  tmr_mode_t     mode;
  logic [2:0]    clksel;
  logic [W-1:0]  cmp_a, cmp_b, cnt;
  logic [NF-1:0] ien, flags, irq, set_vec, clr_vec, ack_vec, wclr_vec;
  logic          adv, cnt_wr, ovf_evt, step_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  tmr_regs #(.W(W)) u_regs (
    .clk(clk), .rst_n(rst_sync), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .mode(mode), .clksel(clksel),
    .cmp_a(cmp_a), .cmp_b(cmp_b), .ien(ien)
  );

  assign adv     = tick && (clksel != 3'd0);
  assign cnt_wr  = bus_wr && (bus_addr == ADDR_COUNT);
  assign step_ok = adv && !cnt_wr;

  tmr_counter #(.W(W)) u_cnt (
    .clk(clk), .rst_n(rst_sync), .adv(adv), .mode(mode), .cmp_a(cmp_a),
    .cnt_wr(cnt_wr), .cnt_wdata(bus_wdata), .cnt(cnt),
    .at_top(cnt_top), .at_bottom(cnt_bottom), .ovf_evt(ovf_evt)
  );

  always_comb begin
    set_vec          = '0;
    set_vec[FLG_OVF] = ovf_evt;
    set_vec[FLG_A]   = step_ok && (cnt == cmp_a);
    set_vec[FLG_B]   = step_ok && (cnt == cmp_b);
    ack_vec          = '0;
    ack_vec[FLG_OVF] = ack_ovf;
    ack_vec[FLG_A]   = ack_cmp_a;
    ack_vec[FLG_B]   = ack_cmp_b;
    wclr_vec = (bus_wr && (bus_addr == ADDR_FLAGS)) ? bus_wdata[NF-1:0] : '0;
    clr_vec  = ack_vec | wclr_vec;
  end

  tmr_flags #(.N(NF)) u_flags (
    .clk(clk), .rst_n(rst_sync), .set_vec(set_vec), .clr_vec(clr_vec),
    .ien(ien), .flags(flags), .irq(irq)
  );

  assign flag_ovf   = flags[FLG_OVF];
  assign flag_cmp_a = flags[FLG_A];
  assign flag_cmp_b = flags[FLG_B];
  assign irq_ovf    = irq[FLG_OVF];
  assign irq_cmp_a  = irq[FLG_A];
  assign irq_cmp_b  = irq[FLG_B];

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      ADDR_CTRL0: bus_rdata[1:0] = mode[1:0];
      ADDR_CTRL1: begin
        bus_rdata[2:0] = clksel;
        bus_rdata[3]   = mode[2];
      end
      ADDR_COUNT: bus_rdata = cnt;
      ADDR_CMPA:  bus_rdata = cmp_a;
      ADDR_CMPB:  bus_rdata = cmp_b;
      ADDR_IEN:   bus_rdata[NF-1:0] = ien;
      ADDR_FLAGS: bus_rdata[NF-1:0] = flags;
      default:    bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/tmr_chk.sv
module tmr_chk
  import tmr_pkg::*;
#(
  parameter int W = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tick,
  input logic [2:0]    clksel,
  input tmr_mode_t     mode,
  input logic          cnt_wr,
  input logic [W-1:0]  bus_wdata,
  input logic [W-1:0]  cnt,
  input logic [W-1:0]  cmp_a,
  input logic [NF-1:0] flags,
  input logic [NF-1:0] set_vec,
  input logic          ack_ovf
);
  logic adv_c;
  assign adv_c = tick && (clksel != 3'd0) && !cnt_wr;

  AST_STOPPED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_wr && ((clksel == 3'd0) || !tick)) |=> $stable(cnt)); // R3

  AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr |=> (cnt == $past(bus_wdata))); // R4

  AST_CTC_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_c && (mode == MODE_CLRCMP) && (cnt == cmp_a)) |=> (cnt == '0)); // R6

  AST_UD_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_c && (mode == MODE_UPDOWN)) |=>
      ((cnt == $past(cnt) + 1'b1) || (cnt == $past(cnt) - 1'b1))); // R7

  AST_CMPA_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_c && (cnt == cmp_a)) |=> flags[FLG_A]); // R8

  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_ovf && !set_vec[FLG_OVF]) |=> !flags[FLG_OVF]); // R9
endmodule

bind updown_timer tmr_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_sync), .tick(tick), .clksel(clksel), .mode(mode),
  .cnt_wr(cnt_wr), .bus_wdata(bus_wdata), .cnt(cnt), .cmp_a(cmp_a),
  .flags(flags), .set_vec(set_vec), .ack_ovf(ack_ovf)
);

// File: tb/updown_timer_test.sv
module updown_timer_test;
  localparam logic [2:0] A_C0 = 3'd0, A_C1 = 3'd1, A_CNT = 3'd2, A_CA = 3'd3,
                         A_CB = 3'd4, A_IEN = 3'd5, A_FLG = 3'd6;

  logic clk = 1'b0;
  logic rst_n, tick, bus_wr, ack_ovf, ack_cmp_a, ack_cmp_b;
  logic [2:0] bus_addr;
  logic [7:0] bus_wdata, bus_rdata;
  logic flag_ovf, flag_cmp_a, flag_cmp_b, irq_ovf, irq_cmp_a, irq_cmp_b;
  logic cnt_top, cnt_bottom;
  int tests = 0, fails = 0;

  always #5 clk = ~clk;

  updown_timer #(.W(8)) uut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ack_ovf(ack_ovf),
    .ack_cmp_a(ack_cmp_a), .ack_cmp_b(ack_cmp_b), .flag_ovf(flag_ovf),
    .flag_cmp_a(flag_cmp_a), .flag_cmp_b(flag_cmp_b), .irq_ovf(irq_ovf),
    .irq_cmp_a(irq_cmp_a), .irq_cmp_b(irq_cmp_b), .cnt_top(cnt_top),
    .cnt_bottom(cnt_bottom)
  );

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; bus_addr = A_CNT;
  endtask

  task automatic rd(input logic [2:0] a, output int v);
    bus_addr = a;
    #1;
    v = int'(bus_rdata);
    bus_addr = A_CNT;
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int v, e, p;
    rst_n = 1'b0; tick = 1'b0; bus_wr = 1'b0; bus_addr = A_CNT; bus_wdata = '0;
    ack_ovf = 1'b0; ack_cmp_a = 1'b0; ack_cmp_b = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state, R2 address 7 reads zero
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), v);
      chk("R1", v, 0);
    end
    chk("R1", {flag_ovf, flag_cmp_a, flag_cmp_b, irq_ovf, irq_cmp_a, irq_cmp_b}, 0);
    chk("R11", {cnt_top, cnt_bottom}, 1);

    // R2 field layout
    wr(A_C0, 8'hFF); rd(A_C0, v); chk("R2", v, 3);
    wr(A_C1, 8'hFF); rd(A_C1, v); chk("R2", v, 15);
    wr(A_C0, 8'h00); wr(A_C1, 8'h00);
    wr(A_CA, 8'hA5); rd(A_CA, v); chk("R2", v, 165);
    wr(A_CB, 8'h5A); rd(A_CB, v); chk("R2", v, 90);
    wr(A_IEN, 8'hFF); rd(A_IEN, v); chk("R2", v, 7);
    wr(A_IEN, 8'h00);

    // R3 stopped timer, count still accessible
    tick = 1'b1;
    repeat (20) @(negedge clk);
    rd(A_CNT, v); chk("R3", v, 0);
    tick = 1'b0;
    wr(A_CNT, 8'd77); rd(A_CNT, v); chk("R3", v, 77);
    wr(A_CNT, 8'd0);

    // R5 normal mode sweep through the wrap, R11 top indication
    wr(A_C1, 8'h01); wr(A_FLG, 8'h07);
    tick = 1'b1;
    for (int n = 1; n <= 300; n++) begin
      @(negedge clk);
      rd(A_CNT, v);
      chk("R5", v, n % 256);
      chk("R5", flag_ovf, int'(n >= 256));
      chk("R11", cnt_top, int'((n % 256) == 255));
    end
    tick = 1'b0;

    // R3 gated ticks
    wr(A_CNT, 8'd0);
    e = 0;
    for (int i = 0; i < 30; i++) begin
      tick = ((i % 3) == 0);
      @(negedge clk);
      if ((i % 3) == 0) e++;
      rd(A_CNT, v);
      chk("R3", v, e);
    end
    tick = 1'b0;

    // R8 compare flags one tick after the match
    wr(A_FLG, 8'h07); wr(A_CNT, 8'd0); wr(A_CA, 8'd10); wr(A_CB, 8'd12);
    tick = 1'b1;
    for (int n = 1; n <= 15; n++) begin
      @(negedge clk);
      chk("R8", flag_cmp_a, int'(n >= 11));
      chk("R8", flag_cmp_b, int'(n >= 13));
    end
    tick = 1'b0;

    // R9 clear paths
    wr(A_FLG, 8'h00);
    chk("R9", {flag_cmp_a, flag_cmp_b}, 3);
    wr(A_FLG, 8'h02);
    chk("R9", {flag_cmp_a, flag_cmp_b}, 1);
    @(negedge clk); ack_cmp_b = 1'b1;
    @(negedge clk); ack_cmp_b = 1'b0;
    chk("R9", flag_cmp_b, 0);
    // R9 set wins over a simultaneous acknowledge
    wr(A_CNT, 8'd10);
    @(negedge clk); tick = 1'b1; ack_cmp_a = 1'b1;
    @(negedge clk); tick = 1'b0; ack_cmp_a = 1'b0;
    chk("R9", flag_cmp_a, 1);

    // R10 interrupt masking
    wr(A_IEN, 8'h02);
    chk("R10", {irq_ovf, irq_cmp_a, irq_cmp_b}, 2);
    wr(A_IEN, 8'h05);
    chk("R10", {irq_ovf, irq_cmp_a, irq_cmp_b}, 0);
    wr(A_IEN, 8'h02); wr(A_FLG, 8'h07);
    chk("R10", irq_cmp_a, 0);
    wr(A_IEN, 8'h00);

    // R4 write priority over a tick
    wr(A_CNT, 8'd50);
    @(negedge clk); bus_addr = A_CNT; bus_wdata = 8'd100; bus_wr = 1'b1; tick = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
    rd(A_CNT, v); chk("R4", v, 100);
    @(negedge clk); tick = 1'b0;
    rd(A_CNT, v); chk("R4", v, 101);
    wr(A_CA, 8'd120); wr(A_CNT, 8'd120); wr(A_FLG, 8'h07);
    @(negedge clk); bus_addr = A_CNT; bus_wdata = 8'd5; bus_wr = 1'b1; tick = 1'b1;
    @(negedge clk); bus_wr = 1'b0; tick = 1'b0;
    rd(A_CNT, v); chk("R4", v, 5);
    chk("R4", flag_cmp_a, 0);

    // R6 clear-on-compare
    wr(A_C0, 8'h02); wr(A_CA, 8'd5); wr(A_CNT, 8'd0); wr(A_FLG, 8'h07);
    tick = 1'b1;
    for (int n = 1; n <= 20; n++) begin
      @(negedge clk);
      rd(A_CNT, v);
      chk("R6", v, n % 6);
      chk("R6", flag_cmp_a, int'(n >= 6));
    end
    tick = 1'b0;
    chk("R6", flag_ovf, 0);

    // R5 mode code 6 counts as normal (bit 2 is decoded)
    wr(A_C1, 8'h09); wr(A_CNT, 8'd0);
    tick = 1'b1;
    for (int n = 1; n <= 10; n++) begin
      @(negedge clk);
      rd(A_CNT, v);
      chk("R5", v, n);
    end
    tick = 1'b0;

    // R7 up/down triangle over a full period, R11 bottom indication
    wr(A_C1, 8'h01); wr(A_C0, 8'h01); wr(A_CNT, 8'd0); wr(A_FLG, 8'h07);
    tick = 1'b1;
    for (int n = 1; n <= 520; n++) begin
      @(negedge clk);
      p = n % 510;
      e = (p <= 255) ? p : 510 - p;
      rd(A_CNT, v);
      chk("R7", v, e);
      chk("R7", flag_ovf, int'(n >= 510));
      chk("R11", cnt_bottom, int'(e == 0));
    end
    tick = 1'b0;

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule